// File: doc/BRIEF.md
# System Control Port Register Block

This block sits on a simple byte-wide I/O bus as a small system controller. A handful of port addresses hold writable control bits. Their outputs go straight to the rest of the chip: a processor reset request, a little-endian mode flag, a disk activity light and a map-mode bit. The map-mode bit selects how the I/O address decoder elsewhere maps its space. Two password ports store nothing. A write to either one produces a single-cycle toggle pulse for a lock in non-volatile memory. Identification and status ports answer with fixed bytes, and every other address reads as all ones and ignores writes.

Each bus cycle is classified by a three-state access sequencer:

- **ST_IDLE**: no strobe, or both strobes at once.
- **ST_WRITE**: a write strobe alone.
- **ST_READ**: a read strobe alone.

The transitions `go_write`, `go_read` and `go_idle` are taken from any state on the strobes sampled at each clock edge. Control registers update at the edge that samples a write. Lock pulses are Moore outputs of ST_WRITE, so they appear for the one cycle after that edge. Read data is captured at the edge that samples a read and holds until the next accepted read.

Top module: `sysctl_port_regs`

## Requirements
- R1: A write to port 0x092 sets the reset request output to data bit 0. A read of port 0x092 returns 0x00.
- R2: A write to port 0x092 sets the little-endian output to data bit 1. The output changes on no other bus cycle.
- R3: A write to port 0x808 sets the activity light output to data bit 0.
- R4: A write to port 0x810 raises the lock-A pulse, and a write to port 0x812 raises the lock-B pulse. Each pulse is high for exactly the one cycle after the write edge, whatever the data, and the two pulses never rise together.
- R5: Port 0x81C stores only data bits 3:0. A read returns them in bits 3:0 with bits 7:4 zero.
- R6: Port 0x850 stores data bit 0 and drives it on the map-mode output. A read returns it in bit 0 with bits 7:1 zero.
- R7: Fixed ports read as follows: 0x800→0xEF, 0x802→0xAD, 0x803→0xE0, 0x80C→0x3C, 0x810→0x39, 0x818→0x00, 0x823→0x03. Writes to 0x800, 0x802 and 0x803 change nothing.
- R8: Port 0x814 and every unmapped address, including addresses that differ from a mapped port only above bit 11, read 0xFF. Writes to them change no output and no stored register.
- R9: Reset clears the reset request, endian, light and map-mode outputs, both lock pulses, the stored system-control value, and the read data (to 0x00).
- R10: Read data appears at the clock edge that samples the read strobe and holds until the next accepted read.
- R11: A cycle with both strobes high is ignored. No register changes, no lock pulse fires and the read data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | Port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | Processor reset request |
| endian_le | output | 1 | Little-endian mode |
| disk_light | output | 1 | Activity light |
| lock_a_pulse | output | 1 | Lock 1 toggle pulse |
| lock_b_pulse | output | 1 | Lock 2 toggle pulse |
| map_noncontig | output | 1 | I/O map-mode select |

## Verification
The bench builds the block with its default parameters: a 16-bit address and an 8-bit data path. The wide address lets the bench aim accesses at addresses that match a mapped port in the low bits but differ higher up, for example 0x1092 and 0x1850. These show that decoding compares the full address, with no aliasing. The 8-bit path exercises the masking of the 4-bit system-control field and the 1-bit map field against all-ones and patterned data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SPECIAL,
        SEL_CPU_CFG,
        SEL_MOD_FEAT,
        SEL_MOD_STAT,
        SEL_EQUIP,
        SEL_LIGHT,
        SEL_LOCK_A,
        SEL_LOCK_B,
        SEL_CACHE_INV,
        SEL_KEYSW,
        SEL_SYSCTL,
        SEL_CACHE_STAT,
        SEL_MAP
    } port_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ
    } acc_state_e;

    localparam int SYSCTL_W = 4;

endpackage

// File: rtl/sysctl_port_decode.sv
module sysctl_port_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] PORT_SPECIAL    = 'h092,
    parameter logic [ADDR_W-1:0] PORT_CPU_CFG    = 'h800,
    parameter logic [ADDR_W-1:0] PORT_MOD_FEAT   = 'h802,
    parameter logic [ADDR_W-1:0] PORT_MOD_STAT   = 'h803,
    parameter logic [ADDR_W-1:0] PORT_EQUIP      = 'h80C,
    parameter logic [ADDR_W-1:0] PORT_LIGHT      = 'h808,
    parameter logic [ADDR_W-1:0] PORT_LOCK_A     = 'h810,
    parameter logic [ADDR_W-1:0] PORT_LOCK_B     = 'h812,
    parameter logic [ADDR_W-1:0] PORT_CACHE_INV  = 'h814,
    parameter logic [ADDR_W-1:0] PORT_KEYSW      = 'h818,
    parameter logic [ADDR_W-1:0] PORT_SYSCTL     = 'h81C,
    parameter logic [ADDR_W-1:0] PORT_CACHE_STAT = 'h823,
    parameter logic [ADDR_W-1:0] PORT_MAP        = 'h850
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel
);

    // Full-width compare: no aliasing on upper address bits.
    always_comb begin
        if      (addr == PORT_SPECIAL)    sel = SEL_SPECIAL;
        else if (addr == PORT_CPU_CFG)    sel = SEL_CPU_CFG;
        else if (addr == PORT_MOD_FEAT)   sel = SEL_MOD_FEAT;
        else if (addr == PORT_MOD_STAT)   sel = SEL_MOD_STAT;
        else if (addr == PORT_EQUIP)      sel = SEL_EQUIP;
        else if (addr == PORT_LIGHT)      sel = SEL_LIGHT;
        else if (addr == PORT_LOCK_A)     sel = SEL_LOCK_A;
        else if (addr == PORT_LOCK_B)     sel = SEL_LOCK_B;
        else if (addr == PORT_CACHE_INV)  sel = SEL_CACHE_INV;
        else if (addr == PORT_KEYSW)      sel = SEL_KEYSW;
        else if (addr == PORT_SYSCTL)     sel = SEL_SYSCTL;
        else if (addr == PORT_CACHE_STAT) sel = SEL_CACHE_STAT;
        else if (addr == PORT_MAP)        sel = SEL_MAP;
        else                              sel = SEL_NONE;
    end

endmodule

// File: rtl/sysctl_access_fsm.sv
module sysctl_access_fsm
    import sysctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stb,
    input  logic      rd_stb,
    input  port_sel_e sel,
    output logic      wr_en,
    output logic      rd_en,
    output logic      lock_a,
    output logic      lock_b
);

    acc_state_e state_q, state_d;
    port_sel_e  sel_q;

    // Accept a strobe only when it is alone.
    assign wr_en = wr_stb & ~rd_stb;
    assign rd_en = rd_stb & ~wr_stb;

    // go_write / go_read / go_idle, from any state
    always_comb begin
        if (wr_en)      state_d = ST_WRITE;
        else if (rd_en) state_d = ST_READ;
        else            state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= SEL_NONE;
        end else begin
            state_q <= state_d;
            sel_q   <= sel;
        end
    end

    // Moore outputs: pulses live for the single ST_WRITE cycle.
    always_comb begin
        lock_a = 1'b0;
        lock_b = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  ;
            ST_WRITE: begin
                lock_a = (sel_q == SEL_LOCK_A);
                lock_b = (sel_q == SEL_LOCK_B);
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/sysctl_ctl_regs.sv
module sysctl_ctl_regs
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  port_sel_e           sel,
    input  logic [DATA_W-1:0]   wdata,
    output logic                rst_req,
    output logic                endian_le,
    output logic                light,
    output logic [SYSCTL_W-1:0] sysctl,
    output logic                map_mode
);

    localparam int RST_BIT    = 0;
    localparam int ENDIAN_BIT = 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req   <= 1'b0;
            endian_le <= 1'b0;
            light     <= 1'b0;
            sysctl    <= '0;
            map_mode  <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_SPECIAL: begin
                    rst_req   <= wdata[RST_BIT];
                    endian_le <= wdata[ENDIAN_BIT];
                end
                SEL_LIGHT:  light    <= wdata[0];
                SEL_SYSCTL: sysctl   <= wdata[SYSCTL_W-1:0];
                SEL_MAP:    map_mode <= wdata[0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/sysctl_rd_path.sv
module sysctl_rd_path
    import sysctl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] VAL_CPU_CFG    = 'hEF,
    parameter logic [DATA_W-1:0] VAL_MOD_FEAT   = 'hAD,
    parameter logic [DATA_W-1:0] VAL_MOD_STAT   = 'hE0,
    parameter logic [DATA_W-1:0] VAL_EQUIP      = 'h3C,
    parameter logic [DATA_W-1:0] VAL_EXT_FEAT   = 'h39,
    parameter logic [DATA_W-1:0] VAL_KEYSW      = 'h00,
    parameter logic [DATA_W-1:0] VAL_CACHE_STAT = 'h03
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  port_sel_e           sel,
    input  logic [SYSCTL_W-1:0] sysctl,
    input  logic                map_mode,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        unique case (sel)
            SEL_SPECIAL:    rd_val = '0;
            SEL_CPU_CFG:    rd_val = VAL_CPU_CFG;
            SEL_MOD_FEAT:   rd_val = VAL_MOD_FEAT;
            SEL_MOD_STAT:   rd_val = VAL_MOD_STAT;
            SEL_EQUIP:      rd_val = VAL_EQUIP;
            SEL_LOCK_A:     rd_val = VAL_EXT_FEAT;
            SEL_KEYSW:      rd_val = VAL_KEYSW;
            SEL_SYSCTL:     rd_val = {{(DATA_W-SYSCTL_W){1'b0}}, sysctl};
            SEL_CACHE_STAT: rd_val = VAL_CACHE_STAT;
            SEL_MAP:        rd_val = {{(DATA_W-1){1'b0}}, map_mode};
            default:        rd_val = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

endmodule

// File: rtl/sysctl_port_regs.sv
module sysctl_port_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT_SPECIAL = 'h092,
    parameter logic [ADDR_W-1:0] PORT_LOCK_A  = 'h810,
    parameter logic [ADDR_W-1:0] PORT_LOCK_B  = 'h812,
    parameter logic [ADDR_W-1:0] PORT_SYSCTL  = 'h81C,
    parameter logic [ADDR_W-1:0] PORT_MAP     = 'h850
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              rst_req,
    output logic              endian_le,
    output logic              disk_light,
    output logic              lock_a_pulse,
    output logic              lock_b_pulse,
    output logic              map_noncontig
);

    port_sel_e           sel;
    logic                wr_en, rd_en;
    logic [SYSCTL_W-1:0] sysctl;

    sysctl_port_decode #(
        .ADDR_W(ADDR_W), .PORT_SPECIAL(PORT_SPECIAL), .PORT_LOCK_A(PORT_LOCK_A),
        .PORT_LOCK_B(PORT_LOCK_B), .PORT_SYSCTL(PORT_SYSCTL), .PORT_MAP(PORT_MAP)
    ) u_decode (
        .addr(io_addr),
        .sel (sel)
    );

    sysctl_access_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(io_wr),
        .rd_stb(io_rd),
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .lock_a(lock_a_pulse),
        .lock_b(lock_b_pulse)
    );

    sysctl_ctl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (io_wdata),
        .rst_req  (rst_req),
        .endian_le(endian_le),
        .light    (disk_light),
        .sysctl   (sysctl),
        .map_mode (map_noncontig)
    );

    sysctl_rd_path #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (sel),
        .sysctl  (sysctl),
        .map_mode(map_noncontig),
        .rdata   (io_rdata)
    );

endmodule

// File: rtl/sysctl_port_regs_chk.sv
module sysctl_port_regs_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT_SPECIAL = 'h092,
    parameter logic [ADDR_W-1:0] PORT_LOCK_A  = 'h810,
    parameter logic [ADDR_W-1:0] PORT_LOCK_B  = 'h812,
    parameter logic [ADDR_W-1:0] PORT_SYSCTL  = 'h81C,
    parameter logic [ADDR_W-1:0] PORT_MAP     = 'h850
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              rst_req,
    input logic              endian_le,
    input logic              lock_a_pulse,
    input logic              lock_b_pulse,
    input logic              map_noncontig
);

    logic wr_only, rd_only;
    assign wr_only = io_wr & ~io_rd;
    assign rd_only = io_rd & ~io_wr;

    assert_rstreq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && io_addr == PORT_SPECIAL) |=> (rst_req == $past(io_wdata[0])));

    assert_endian_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && io_addr == PORT_SPECIAL) |=> (endian_le == $past(io_wdata[1])));

    assert_endian_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_only && io_addr == PORT_SPECIAL) |=> $stable(endian_le));

    assert_lock_a_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && io_addr == PORT_LOCK_A) |=> lock_a_pulse);

    assert_lock_a_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_only && io_addr == PORT_LOCK_A) |=> !lock_a_pulse);

    assert_lock_b_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_only && io_addr == PORT_LOCK_B) |=> !lock_b_pulse);

    assert_lock_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lock_a_pulse, lock_b_pulse}));

    assert_sysctl_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_only && io_addr == PORT_SYSCTL) |=> (io_rdata[DATA_W-1:4] == '0));

    assert_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && io_addr == PORT_MAP) |=> (map_noncontig == $past(io_wdata[0])));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_only |=> $stable(io_rdata));

    assert_both_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_rd) |=> ($stable(rst_req) && $stable(map_noncontig) && !lock_a_pulse && !lock_b_pulse));

endmodule

bind sysctl_port_regs sysctl_port_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_SPECIAL(PORT_SPECIAL),
    .PORT_LOCK_A(PORT_LOCK_A), .PORT_LOCK_B(PORT_LOCK_B),
    .PORT_SYSCTL(PORT_SYSCTL), .PORT_MAP(PORT_MAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .rst_req(rst_req), .endian_le(endian_le),
    .lock_a_pulse(lock_a_pulse), .lock_b_pulse(lock_b_pulse), .map_noncontig(map_noncontig)
);

// File: tb/sysctl_port_regs_tb_top.sv
module sysctl_port_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic              io_wr = 1'b0;
    logic              io_rd = 1'b0;
    logic [DATA_W-1:0] io_wdata = '0;
    logic [DATA_W-1:0] io_rdata;
    logic rst_req, endian_le, disk_light, lock_a_pulse, lock_b_pulse, map_noncontig;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct { logic [DATA_W-1:0] exp; string req; } rd_item_t;
    rd_item_t exp_q[$];
    logic     rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .rst_req(rst_req), .endian_le(endian_le),
        .disk_light(disk_light), .lock_a_pulse(lock_a_pulse), .lock_b_pulse(lock_b_pulse),
        .map_noncontig(map_noncontig)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Monitor: compare read data one edge after an accepted read strobe.
    always @(posedge clk) rd_seen <= io_rd && !io_wr;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: actual 0x%02h expected none (empty queue)", io_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(it.req, io_rdata, it.exp);
            end
        end
    end

    task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
        rd_item_t it;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        it.exp = e; it.req = req;
        exp_q.push_back(it);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic chk_outs(input string req, input logic [5:0] exp);
        check(req, {2'b00, rst_req, endian_le, disk_light, lock_a_pulse, lock_b_pulse, map_noncontig},
              {2'b00, exp});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state (order: rst, endian, light, lockA, lockB, map)
        chk_outs("R9 outputs", 6'b000000);
        check("R9 rdata", io_rdata, 8'h00);
        rst_n = 1'b1;
        do_rd('h81C, 8'h00, "R9 sysctl");
        do_rd('h850, 8'h00, "R9 map");

        // R1 / R2
        do_wr('h092, 8'h01); chk_outs("R1 reset bit", 6'b100000);
        do_wr('h092, 8'h02); chk_outs("R2 endian bit", 6'b010000);
        do_wr('h092, 8'hFF); chk_outs("R1 R2 both", 6'b110000);
        do_rd('h092, 8'h00, "R1 read port");
        do_wr('h092, 8'h00); chk_outs("R1 R2 clear", 6'b000000);

        // R3
        do_wr('h808, 8'hFF); chk_outs("R3 light on", 6'b001000);
        do_wr('h808, 8'hFE); chk_outs("R3 light off", 6'b000000);

        // R4: pulse is high in the cycle after the write edge, then low
        do_wr('h810, 8'h00); chk_outs("R4 lock a pulse", 6'b000100);
        @(negedge clk);      chk_outs("R4 lock a gone", 6'b000000);
        do_wr('h812, 8'hA5); chk_outs("R4 lock b pulse", 6'b000010);
        @(negedge clk);      chk_outs("R4 lock b gone", 6'b000000);

        // R5
        do_wr('h81C, 8'hAB); do_rd('h81C, 8'h0B, "R5 mask");
        do_wr('h81C, 8'h7F); do_rd('h81C, 8'h0F, "R5 mask all");

        // R6
        do_wr('h850, 8'hFF); chk_outs("R6 map set", 6'b000001);
        do_rd('h850, 8'h01, "R6 read set");
        do_wr('h850, 8'hFE); chk_outs("R6 map clear", 6'b000000);
        do_rd('h850, 8'h00, "R6 read clear");
        do_wr('h850, 8'h01);

        // R7
        do_rd('h800, 8'hEF, "R7 cpu cfg");
        do_rd('h802, 8'hAD, "R7 feature");
        do_rd('h803, 8'hE0, "R7 status");
        do_rd('h80C, 8'h3C, "R7 equip");
        do_rd('h810, 8'h39, "R7 ext feature");
        do_rd('h818, 8'h00, "R7 keylock");
        do_rd('h823, 8'h03, "R7 cache stat");
        do_wr('h800, 8'h00); do_wr('h802, 8'h00); do_wr('h803, 8'h00);
        do_rd('h800, 8'hEF, "R7 write ignored");
        do_rd('h803, 8'hE0, "R7 write ignored b");

        // R8
        do_rd('h814, 8'hFF, "R8 cache inv");
        do_rd('h801, 8'hFF, "R8 hole");
        do_rd('h1092, 8'hFF, "R8 alias");
        do_wr('h1850, 8'h00); do_wr('h081D, 8'h00); do_wr('h1092, 8'hFF);
        chk_outs("R8 unmapped write", 6'b000001);
        do_rd('h81C, 8'h0F, "R8 sysctl kept");
        do_rd('h850, 8'h01, "R8 map kept");

        // R10: value held through idle cycles
        repeat (4) @(negedge clk);
        check("R10 hold", io_rdata, 8'h01);

        // R11: both strobes at once
        @(negedge clk);
        io_addr = 'h81C; io_wdata = 8'h03; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        check("R11 rdata held", io_rdata, 8'h01);
        @(negedge clk);
        io_addr = 'h810; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk_outs("R11 no pulse", 6'b000001);
        do_rd('h81C, 8'h0F, "R11 sysctl unchanged");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R10: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule